// File: doc/BRIEF.md
# Two-Step Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame: a low start bit, the data bits least significant first, a parity bit and a high stop bit. The host loads it in two separate steps. A load strobe copies the data bus into a holding register on any clock cycle. A byte-ready indication then moves the held word, with its start and parity bits, into a frame shift register. The frame goes out only when the host also issues a transmit command.

Every move of the controller and shift register waits for a one-cycle baud tick from an external rate divider. Each line bit therefore lasts exactly one tick interval. Between frames the line rests at the mark level (high). `busy` tells the host that a word is committed to the shift register and that the line is not yet free.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset `ser_out` is 1 and `busy` is 0. Whenever `busy` is 0, `ser_out` is 1.
- R2: A cycle with `hold_load` high copies `data_in` into the holding register, with or without a baud tick. The next committed frame carries that value.
- R3: In idle, a tick cycle with `byte_rdy` high commits the held word and raises `busy`. The line stays 1 for any number of ticks until a tick arrives together with `tx_go`.
- R4: A tick with `tx_go` high while a word is committed starts the frame. After that clock edge `ser_out` is 0, the start bit, for one tick interval.
- R5: On each of the next DATA_W ticks `ser_out` presents the following data bit, bit 0 first.
- R6: The next tick presents the parity bit. With ODD_PARITY=0 this is the XOR of all data bits (even parity). With ODD_PARITY=1 it is the inverse.
- R7: The next tick presents the stop bit 1 with `busy` still high. The tick after that returns the block to idle and `busy` falls.
- R8: In a cycle without `baud_tick`, `ser_out` and `busy` keep their values at the next edge, whatever the other inputs do.
- R9: `tx_go` has no effect in idle or during a frame, and `byte_rdy` has no effect while `busy` is high.
- R10: Loading the holding register after a word has been committed, either before or during its frame, leaves that frame's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable, one per bit interval |
| data_in | input | DATA_W | Parallel data bus |
| hold_load | input | 1 | Copies `data_in` into the holding register |
| byte_rdy | input | 1 | Host has a valid word; commits it to the shift register |
| tx_go | input | 1 | Transmit command; starts the committed frame |
| ser_out | output | 1 | Serial line, high at rest |
| busy | output | 1 | High from commit until the end of the stop bit |

## Verification
The hardest states to reach are the ones where host inputs collide with a frame already committed. Examples are a holding-register load arriving between commit and start, and `byte_rdy` or `tx_go` pulses landing on mid-frame ticks. The stimulus injects these from a seeded random source, alongside directed all-zero, all-one and single-bit words. Random idle gaps between ticks let each bit interval be checked for stability as well as for its value.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   // frame bits beyond the data word: start, parity, stop
   localparam int unsigned FRAME_OVERHEAD = 3;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              par
);

   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (load)
         hold_q <= din;
   end

   assign dout = hold_q;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par = ~(^hold_q);
      end else begin : g_even
         assign par = ^hold_q;
      end
   endgenerate

   AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> hold_q == $past(din)); // R2

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
   parameter int unsigned WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             shift,
   output logic             ser_bit
);

   logic [WIDTH-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '1;
      else if (load)
         sh_q <= load_val;
      else if (shift)
         sh_q <= {1'b1, sh_q[WIDTH-1:1]};
   end

   assign ser_bit = sh_q[0];

   AST_FILL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> sh_q[WIDTH-1]); // R7

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> ser_bit == $past(sh_q[1])); // R5

endmodule

// File: rtl/uart_tx_bitcnt.sv
module uart_tx_bitcnt #(
   parameter int unsigned LAST = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_last
);

   localparam int unsigned CW = $clog2(LAST + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + 1'b1;
   end

   assign at_last = (cnt_q == CW'(LAST));

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LAST)); // R7

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
   import uart_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic byte_rdy,
   input  logic tx_go,
   input  logic at_last,
   output logic load_sh,
   output logic shift,
   output logic clr_cnt,
   output logic inc_cnt,
   output logic sending,
   output logic busy
);

   tx_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      load_sh = 1'b0;
      shift   = 1'b0;
      clr_cnt = 1'b0;
      inc_cnt = 1'b0;
      if (tick) begin
         unique case (state_q)
            TX_IDLE: begin
               if (byte_rdy) begin
                  load_sh = 1'b1;
                  state_d = TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (tx_go) begin
                  clr_cnt = 1'b1;
                  state_d = TX_SEND;
               end
            end
            TX_SEND: begin
               if (at_last) begin
                  clr_cnt = 1'b1;
                  state_d = TX_IDLE;
               end else begin
                  shift   = 1'b1;
                  inc_cnt = 1'b1;
               end
            end
            default: state_d = TX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= TX_IDLE;
      else
         state_q <= state_d;
   end

   assign busy    = (state_q != TX_IDLE);
   assign sending = (state_q == TX_SEND);

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_WAIT && !(tick && tx_go)) |=> state_q == TX_WAIT); // R3

   AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_IDLE) |=> state_q != TX_SEND); // R4

   AST_END_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(at_last)); // R7

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [DATA_W-1:0] data_in,
   input  logic              hold_load,
   input  logic              byte_rdy,
   input  logic              tx_go,
   output logic              ser_out,
   output logic              busy
);

   localparam int unsigned SH_W = DATA_W + 2;
   localparam int unsigned LAST = DATA_W + FRAME_OVERHEAD - 1;

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("uart_tx_frame: DATA_W must be within 1..32");
      end
   endgenerate

   logic [DATA_W-1:0] held;
   logic              held_par;
   logic              load_sh, shift, clr_cnt, inc_cnt, at_last, sending;
   logic              ser_bit;

   uart_tx_hold #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hold_load),
      .din   (data_in),
      .dout  (held),
      .par   (held_par)
   );

   uart_tx_shifter #(.WIDTH(SH_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_sh),
      .load_val ({held_par, held, 1'b0}),
      .shift    (shift),
      .ser_bit  (ser_bit)
   );

   uart_tx_bitcnt #(.LAST(LAST)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_cnt),
      .inc     (inc_cnt),
      .at_last (at_last)
   );

   uart_tx_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .byte_rdy (byte_rdy),
      .tx_go    (tx_go),
      .at_last  (at_last),
      .load_sh  (load_sh),
      .shift    (shift),
      .clr_cnt  (clr_cnt),
      .inc_cnt  (inc_cnt),
      .sending  (sending),
      .busy     (busy)
   );

   // line rests at mark until the frame is started
   assign ser_out = sending ? ser_bit : 1'b1;

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser_out); // R1

   AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> ($stable(ser_out) && $stable(busy))); // R8

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sending) |-> !ser_out); // R4

   AST_GO_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !byte_rdy) |=> !busy); // R9

endmodule

// File: tb/uart_tx_frame_tb.sv
module uart_tx_frame_tb;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          baud_tick = 1'b0;
   logic [DW-1:0] data_in = '0;
   logic          hold_load = 1'b0;
   logic          byte_rdy = 1'b0;
   logic          tx_go = 1'b0;
   logic          ser_out;
   logic          busy;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   uart_tx_frame #(.DATA_W(DW), .ODD_PARITY(1'b0)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .data_in   (data_in),
      .hold_load (hold_load),
      .byte_rdy  (byte_rdy),
      .tx_go     (tx_go),
      .ser_out   (ser_out),
      .busy      (busy)
   );

   function automatic logic even_par(input logic [DW-1:0] w);
      logic p = 1'b0;
      for (int i = 0; i < DW; i++) p ^= w[i];
      return p;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one tick cycle with chosen host inputs, then a random quiet gap
   // whose cycles must leave the outputs unchanged (R8)
   task automatic tick(input logic go, input logic rdy, input logic ld,
                       input logic [DW-1:0] d);
      logic s_out, s_busy;
      @(negedge clk);
      baud_tick = 1'b1; tx_go = go; byte_rdy = rdy; hold_load = ld; data_in = d;
      @(negedge clk);
      baud_tick = 1'b0; tx_go = 1'b0; byte_rdy = 1'b0; hold_load = 1'b0;
      s_out = ser_out; s_busy = busy;
      for (int g = 0; g < int'($urandom_range(2, 0)); g++) begin
         tx_go = $urandom_range(1, 0) == 1;
         byte_rdy = $urandom_range(1, 0) == 1;
         @(negedge clk);
         chk("R8 quiet ser_out", ser_out, s_out);
         chk("R8 quiet busy", busy, s_busy);
      end
      tx_go = 1'b0; byte_rdy = 1'b0;
   endtask

   task automatic load_hold(input logic [DW-1:0] d);
      @(negedge clk);
      hold_load = 1'b1; data_in = d;
      @(negedge clk);
      hold_load = 1'b0;
   endtask

   // full frame of word w; noisy injects host inputs that must be ignored
   task automatic frame(input logic [DW-1:0] w, input bit noisy, input int waits);
      load_hold(w);                                    // R2
      tick(1'b0, 1'b1, 1'b0, '0);
      chk("R3 busy after commit", busy, 1'b1);
      chk("R3 line mark before go", ser_out, 1'b1);
      for (int k = 0; k < waits; k++) begin
         tick(1'b0, noisy, noisy, ~w);                 // R10 reload while waiting
         chk("R3 still waiting", ser_out, 1'b1);
         chk("R9 byte_rdy ignored busy", busy, 1'b1);
      end
      tick(1'b1, 1'b0, 1'b0, '0);
      chk("R4 start bit", ser_out, 1'b0);
      for (int i = 0; i < DW; i++) begin
         tick(noisy, noisy, noisy, logic'($urandom()) ? 8'hA5 : 8'h3C);
         chk("R5 data bit", ser_out, w[i]);
         chk("R9 busy mid frame", busy, 1'b1);
      end
      tick(noisy, 1'b0, 1'b0, '0);
      chk("R6 parity bit", ser_out, even_par(w));
      tick(noisy, noisy, 1'b0, '0);
      chk("R7 stop bit", ser_out, 1'b1);
      chk("R7 busy during stop", busy, 1'b1);
      tick(1'b0, 1'b0, 1'b0, '0);
      chk("R7 busy falls", busy, 1'b0);
      chk("R1 mark after frame", ser_out, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk("R1 reset ser_out", ser_out, 1'b1);
      chk("R1 reset busy", busy, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: transmit command in idle does nothing
      tick(1'b1, 1'b0, 1'b0, '0);
      chk("R9 go in idle busy", busy, 1'b0);
      chk("R9 go in idle line", ser_out, 1'b1);

      // R8: byte_rdy without a tick does not commit
      @(negedge clk); byte_rdy = 1'b1;
      @(negedge clk); byte_rdy = 1'b0;
      chk("R8 no tick no commit", busy, 1'b0);

      // R2: load on a non-tick cycle then commit
      frame(8'h00, 1'b0, 0);
      frame(8'hFF, 1'b0, 1);
      frame(8'h01, 1'b1, 2);
      frame(8'h80, 1'b1, 3);
      frame(8'h96, 1'b1, 0);

      for (int r = 0; r < 20; r++)
         frame(DW'($urandom()), $urandom_range(1, 0) == 1, int'($urandom_range(3, 0)));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule